// File: doc/BRIEF.md
# Indexed Auto-Stepping Memory Window Port

This block gives a CPU byte-wide access to a 2 MB external RAM through a small set of byte registers. The registers are a 24-bit base pointer, a 16-bit index, a 16-bit step amount and a mode byte. A read or write of the data port starts one RAM transaction. The RAM address is either the base alone or the base plus the index. The index can be taken as unsigned or as two's complement. The address is truncated to 21 bits, so accesses wrap inside the 2 MB space.

After each data access the block can advance either the base or the index by the step amount. The step amount can be unsigned or sign-extended. With a step of all ones in signed form and the index as target, the port works as a 16-bit down counter. The index can also be folded into the base on command: any write to the fold byte does this, and so does a write to the index high byte when the mode byte selects that behaviour.

The CPU side is a plain register bus. `bus_done` pulses once for each accepted strobe, and for a read the byte is on `bus_rdata` during that pulse. The RAM side is a request/acknowledge port. Decoding across several such ports lives outside this block.

Top module: `mem_window_port`

## Requirements
- R1: After reset every register byte (selects 2 to 9) reads back as zero, and `ram_req` is low.
- R2: The byte selects are: 0 and 1 both the data port; 2, 3, 4 the base low, middle and high bytes; 5 and 6 the index low and high bytes; 7 and 8 the step low and high bytes; 9 the mode byte; 10 the fold trigger. Each register byte reads back its value, and the mode byte returns all 8 bits.
- R3: With mode bit 1 clear, the RAM address of a data access is base bits 20:0.
- R4: With mode bit 1 set, the RAM address is bits 20:0 of base plus the index. The index is sign-extended to 24 bits when mode bit 3 is set and zero-extended when it is clear. The base keeps all 24 bits.
- R5: A read at select 0 or 1 returns the RAM byte on `bus_rdata` with `bus_done`. A write at select 0 or 1 issues a RAM write of the bus byte.
- R6: With mode bits 0 and 4 set, each data access adds the step to the base, modulo 2^24. The step is sign-extended when mode bit 2 is set and zero-extended when it is clear.
- R7: With mode bit 0 set and bit 4 clear, each data access adds the step to the index, modulo 2^16, and the base is unchanged.
- R8: The step is applied only after the RAM access completes, so each access uses the address from before its own step.
- R9: Any write to select 10, whatever the value, adds the index (extended per mode bit 3) to the base and leaves the index unchanged.
- R10: When mode bits 6:5 equal 10, a write to select 6 stores the index high byte and then adds the new index (extended per mode bit 3) to the base. With any other value of bits 6:5, a write to select 6 leaves the base alone.
- R11: `ram_req` stays high with a stable `ram_addr` until `ram_ack`. `bus_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte select |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rdata | output | 8 | Read data, valid with bus_done |
| bus_done | output | 1 | Access complete pulse |
| ram_req | output | 1 | RAM request, held until acknowledged |
| ram_we | output | 1 | RAM write enable for the current request |
| ram_addr | output | 21 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid with ram_ack |
| ram_ack | input | 1 | RAM acknowledge |

## Verification
The bench builds the port with its default parameters: a 24-bit base, a 16-bit index and step, and a 21-bit RAM address. With these widths the 2 MB wrap, the 24-bit base wrap and the 16-bit index wrap can all be reached with a handful of register writes. For example, a base of 0x1FFFFF with an index of 2 reaches address 1, and a base of 0xFFFFFF stepped by one returns to zero. Because the index is exactly 16 bits, an all-ones signed step gives a countdown whose address sequence the bench can predict access by access.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  localparam int unsigned BYTE_W = 8;

  // mode byte bit positions
  localparam int unsigned MB_STEP_EN     = 0;
  localparam int unsigned MB_INDEXED     = 1;
  localparam int unsigned MB_STEP_SIGNED = 2;
  localparam int unsigned MB_IDX_SIGNED  = 3;
  localparam int unsigned MB_STEP_BASE   = 4;
  localparam int unsigned MB_FOLD_LO     = 5;
  localparam int unsigned MB_FOLD_HI     = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_STEP = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mwp_regfile.sv
module mwp_regfile
  import mwp_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned BASE_W = 24,
  parameter int unsigned IDX_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    sel,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                step_pulse,
  output logic [BASE_W-1:0]   base_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [BYTE_W-1:0]   mode_o,
  output logic [BYTE_W-1:0]   rd_val
);
  localparam int unsigned BASE_BYTES = BASE_W / BYTE_W;
  localparam int unsigned IDX_BYTES  = IDX_W / BYTE_W;
  localparam int unsigned SEL_BASE0  = 2;
  localparam int unsigned SEL_IDX0   = SEL_BASE0 + BASE_BYTES;
  localparam int unsigned SEL_STEP0  = SEL_IDX0 + IDX_BYTES;
  localparam int unsigned SEL_MODE   = SEL_STEP0 + IDX_BYTES;
  localparam int unsigned SEL_FOLD   = SEL_MODE + 1;
  localparam int unsigned SEL_IDX_HI = SEL_IDX0 + IDX_BYTES - 1;
  localparam int unsigned EXT_W      = BASE_W - IDX_W;

  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q, idx_wr;
  logic [IDX_W-1:0]  step_q;
  logic [BYTE_W-1:0] mode_q;

  function automatic logic [BASE_W-1:0] widen(input logic [IDX_W-1:0] v, input logic sgn);
    widen = sgn ? {{EXT_W{v[IDX_W-1]}}, v} : {{EXT_W{1'b0}}, v};
  endfunction

  // index value after a byte write, used for storage and for the high-byte fold
  always_comb begin
    idx_wr = idx_q;
    for (int i = 0; i < IDX_BYTES; i++)
      if (sel == SEL_W'(SEL_IDX0 + i)) idx_wr[BYTE_W*i +: BYTE_W] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
      step_q <= '0;
      mode_q <= '0;
    end else if (step_pulse) begin
      if (mode_q[MB_STEP_EN]) begin
        if (mode_q[MB_STEP_BASE])
          base_q <= base_q + widen(step_q, mode_q[MB_STEP_SIGNED]);
        else
          idx_q <= idx_q + step_q;
      end
    end else if (wr_en) begin
      for (int i = 0; i < BASE_BYTES; i++)
        if (sel == SEL_W'(SEL_BASE0 + i)) base_q[BYTE_W*i +: BYTE_W] <= wr_data;
      for (int i = 0; i < IDX_BYTES; i++)
        if (sel == SEL_W'(SEL_STEP0 + i)) step_q[BYTE_W*i +: BYTE_W] <= wr_data;
      idx_q <= idx_wr;
      if (sel == SEL_W'(SEL_MODE)) mode_q <= wr_data;
      if (sel == SEL_W'(SEL_FOLD))
        base_q <= base_q + widen(idx_q, mode_q[MB_IDX_SIGNED]);
      if (sel == SEL_W'(SEL_IDX_HI) && mode_q[MB_FOLD_HI] && !mode_q[MB_FOLD_LO])
        base_q <= base_q + widen(idx_wr, mode_q[MB_IDX_SIGNED]);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < BASE_BYTES; i++)
      if (sel == SEL_W'(SEL_BASE0 + i)) rd_val = base_q[BYTE_W*i +: BYTE_W];
    for (int i = 0; i < IDX_BYTES; i++) begin
      if (sel == SEL_W'(SEL_IDX0 + i))  rd_val = idx_q[BYTE_W*i +: BYTE_W];
      if (sel == SEL_W'(SEL_STEP0 + i)) rd_val = step_q[BYTE_W*i +: BYTE_W];
    end
    if (sel == SEL_W'(SEL_MODE)) rd_val = mode_q;
  end

  assign base_o = base_q;
  assign idx_o  = idx_q;
  assign mode_o = mode_q;

  AST_IDX_STEP_KEEPS_BASE: assert property (@(posedge clk) disable iff (rst)
    step_pulse && mode_q[MB_STEP_EN] && !mode_q[MB_STEP_BASE] |=> $stable(base_q)); // R7

  AST_FOLD_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
    wr_en && !step_pulse && sel == SEL_W'(SEL_FOLD) |=> $stable(idx_q)); // R9
endmodule

// File: rtl/mwp_addr_gen.sv
module mwp_addr_gen #(
  parameter int unsigned BASE_W = 24,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned RAM_AW = 21
) (
  input  logic [BASE_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              indexed,
  input  logic              idx_signed,
  output logic [RAM_AW-1:0] addr
);
  localparam int unsigned EXT_W = BASE_W - IDX_W;

  logic [BASE_W-1:0] idx_ext;
  logic [BASE_W-1:0] sum;

  always_comb begin
    idx_ext = idx_signed ? {{EXT_W{idx[IDX_W-1]}}, idx} : {{EXT_W{1'b0}}, idx};
    sum     = indexed ? base + idx_ext : base;
    addr    = RAM_AW'(sum);
  end
endmodule

// File: rtl/mwp_seq.sv
module mwp_seq
  import mwp_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned RAM_AW = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_done,
  input  logic [RAM_AW-1:0] eff_addr,
  input  logic [BYTE_W-1:0] reg_rd_val,
  output logic              reg_wr_en,
  output logic              step_pulse,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  input  logic              ram_ack
);
  seq_state_t state;
  logic       is_data;

  assign is_data    = bus_addr < SEL_W'(2);
  assign reg_wr_en  = (state == SEQ_IDLE) && bus_wr && !is_data;
  assign step_pulse = (state == SEQ_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      bus_rdata <= '0;
      bus_done  <= 1'b0;
      ram_req   <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      bus_done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (is_data && (bus_rd || bus_wr)) begin
            ram_req   <= 1'b1;
            ram_we    <= bus_wr;
            ram_addr  <= eff_addr;
            ram_wdata <= bus_wdata;
            state     <= SEQ_WAIT;
          end else if (bus_rd) begin
            bus_rdata <= reg_rd_val;
            bus_done  <= 1'b1;
          end else if (bus_wr) begin
            bus_done  <= 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (ram_ack) begin
            ram_req <= 1'b0;
            ram_we  <= 1'b0;
            if (!ram_we) bus_rdata <= ram_rdata;
            state   <= SEQ_STEP;
          end
        end
        default: begin
          bus_done <= 1'b1;
          state    <= SEQ_IDLE;
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    ram_req && !ram_ack |=> ram_req && $stable(ram_addr)); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_done |=> !bus_done); // R11
endmodule

// File: rtl/mem_window_port.sv
module mem_window_port
  import mwp_pkg::*;
#(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned BASE_W = 24,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned RAM_AW = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  output logic              bus_done,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  input  logic              ram_ack
);
  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] mode;
  logic [BYTE_W-1:0] reg_rd_val;
  logic [RAM_AW-1:0] eff_addr;
  logic              reg_wr_en;
  logic              step_pulse;

  mwp_regfile #(.SEL_W(SEL_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .sel        (bus_addr),
    .wr_data    (bus_wdata),
    .step_pulse (step_pulse),
    .base_o     (base),
    .idx_o      (idx),
    .mode_o     (mode),
    .rd_val     (reg_rd_val)
  );

  mwp_addr_gen #(.BASE_W(BASE_W), .IDX_W(IDX_W), .RAM_AW(RAM_AW)) u_agen (
    .base       (base),
    .idx        (idx),
    .indexed    (mode[MB_INDEXED]),
    .idx_signed (mode[MB_IDX_SIGNED]),
    .addr       (eff_addr)
  );

  mwp_seq #(.SEL_W(SEL_W), .RAM_AW(RAM_AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .bus_done   (bus_done),
    .eff_addr   (eff_addr),
    .reg_rd_val (reg_rd_val),
    .reg_wr_en  (reg_wr_en),
    .step_pulse (step_pulse),
    .ram_req    (ram_req),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata),
    .ram_ack    (ram_ack)
  );

  AST_BASE_FROZEN_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ram_req |=> $stable(base)); // R8

  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    ram_req && !mode[MB_INDEXED] |-> ram_addr == base[RAM_AW-1:0]); // R3
endmodule

// File: tb/sim_mem_window_port.sv
module sim_mem_window_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_done;
  logic        ram_req, ram_we;
  logic [20:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        ram_ack = 1'b0;

  logic [20:0] last_addr = '0;
  logic        last_we = 1'b0;
  logic [7:0]  last_wdata = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ram_ack(ram_ack)
  );

  function automatic logic [7:0] pat(input logic [20:0] a);
    pat = a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction

  // RAM model: acknowledges one cycle after a request appears
  always @(posedge clk) begin
    if (rst) ram_ack <= 1'b0;
    else begin
      ram_ack <= ram_req && !ram_ack;
      if (ram_req && !ram_ack) begin
        last_addr <= ram_addr;
        last_we   <= ram_we;
        if (ram_we) last_wdata <= ram_wdata;
        ram_rdata <= pat(ram_addr);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_op(input logic [3:0] a, input logic w, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = !w; bus_wr = w;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    while (!bus_done) @(negedge clk);
    q = bus_rdata;
    @(negedge clk);
    chk("R11 done one cycle", {31'b0, bus_done}, 32'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus_op(a, 1'b1, d, q);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    bus_op(a, 1'b0, 8'h00, q);
  endtask

  task automatic set_base(input logic [23:0] v);
    wr(4'd2, v[7:0]); wr(4'd3, v[15:8]); wr(4'd4, v[23:16]);
  endtask

  task automatic set_idx(input logic [15:0] v);
    wr(4'd5, v[7:0]); wr(4'd6, v[15:8]);
  endtask

  task automatic set_step(input logic [15:0] v);
    wr(4'd7, v[7:0]); wr(4'd8, v[15:8]);
  endtask

  task automatic get_base(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'd2, b0); rd(4'd3, b1); rd(4'd4, b2);
    v = {b2, b1, b0};
  endtask

  task automatic get_idx(output logic [15:0] v);
    logic [7:0] b0, b1;
    rd(4'd5, b0); rd(4'd6, b1);
    v = {b1, b0};
  endtask

  // data read at select a, checks address and returned byte
  task automatic data_read(input logic [3:0] a, input logic [20:0] exp_addr, input string tag);
    logic [7:0] q;
    rd(a, q);
    chk({tag, " address"}, {11'b0, last_addr}, {11'b0, exp_addr});
    chk({tag, " data"}, {24'b0, q}, {24'b0, pat(exp_addr)});
    chk("R11 request released", {31'b0, ram_req}, 32'h0);
  endtask

  task automatic t_reset;
    logic [7:0] q;
    chk("R1 ram_req after reset", {31'b0, ram_req}, 32'h0);
    for (int s = 2; s <= 9; s++) begin
      rd(4'(s), q);
      chk("R1 register zero", {24'b0, q}, 32'h0);
    end
  endtask

  task automatic t_map;
    logic [7:0] q;
    set_base(24'hF23456); set_idx(16'hBEEF); set_step(16'hC0DE);
    rd(4'd2, q); chk("R2 base low", {24'b0, q}, 32'h56);
    rd(4'd3, q); chk("R2 base mid", {24'b0, q}, 32'h34);
    rd(4'd4, q); chk("R2 base high", {24'b0, q}, 32'hF2);
    rd(4'd5, q); chk("R2 index low", {24'b0, q}, 32'hEF);
    rd(4'd6, q); chk("R2 index high", {24'b0, q}, 32'hBE);
    rd(4'd7, q); chk("R2 step low", {24'b0, q}, 32'hDE);
    rd(4'd8, q); chk("R2 step high", {24'b0, q}, 32'hC0);
    wr(4'd9, 8'hFE); rd(4'd9, q); chk("R2 mode all bits", {24'b0, q}, 32'hFE);
    wr(4'd9, 8'h00);
  endtask

  task automatic t_direct;
    logic [23:0] b;
    set_base(24'hF23456); set_idx(16'h1234); wr(4'd9, 8'h00);
    data_read(4'd0, 21'h123456, "R3 direct select 0");
    data_read(4'd1, 21'h123456, "R5 direct select 1");
    get_base(b); chk("R3 base untouched", {8'b0, b}, 32'hF23456);
  endtask

  task automatic t_indexed;
    logic [23:0] b;
    set_base(24'h001000); set_idx(16'h8000); wr(4'd9, 8'h02);
    data_read(4'd0, 21'h009000, "R4 unsigned index");
    wr(4'd9, 8'h0A);
    data_read(4'd0, 21'h1F9000, "R4 signed index");
    set_base(24'h1FFFFF); set_idx(16'h0002); wr(4'd9, 8'h02);
    data_read(4'd0, 21'h000001, "R4 2MB wrap");
    get_base(b); chk("R4 base keeps 24 bits", {8'b0, b}, 32'h1FFFFF);
  endtask

  task automatic t_write;
    wr(4'd9, 8'h00); set_base(24'h000777);
    wr(4'd1, 8'hC3);
    chk("R5 write address", {11'b0, last_addr}, 32'h777);
    chk("R5 write enable", {31'b0, last_we}, 32'h1);
    chk("R5 write data", {24'b0, last_wdata}, 32'hC3);
  endtask

  task automatic t_step_base;
    logic [23:0] b;
    wr(4'd9, 8'h11); set_base(24'h000100); set_step(16'h0010);
    data_read(4'd0, 21'h000100, "R8 first access pre-step");
    data_read(4'd1, 21'h000110, "R6 base stepped");
    get_base(b); chk("R6 base after two steps", {8'b0, b}, 32'h000120);
    wr(4'd9, 8'h15); set_base(24'h000000); set_step(16'hFFFF);
    data_read(4'd0, 21'h000000, "R8 signed step pre-step");
    get_base(b); chk("R6 signed step wraps base", {8'b0, b}, 32'hFFFFFF);
    wr(4'd9, 8'h11);
    data_read(4'd0, 21'h1FFFFF, "R6 unsigned step access");
    get_base(b); chk("R6 unsigned step zero-extends", {8'b0, b}, 32'h00FFFE);
  endtask

  task automatic t_countdown;
    logic [23:0] b;
    logic [15:0] x;
    wr(4'd9, 8'h07); set_base(24'h002000); set_idx(16'h0003); set_step(16'hFFFF);
    data_read(4'd0, 21'h002003, "R8 countdown access 1");
    data_read(4'd0, 21'h002002, "R7 countdown access 2");
    data_read(4'd0, 21'h002001, "R7 countdown access 3");
    get_idx(x); chk("R7 index reached zero", {16'b0, x}, 32'h0);
    get_base(b); chk("R7 base unchanged", {8'b0, b}, 32'h002000);
    data_read(4'd0, 21'h002000, "R7 countdown access 4");
    get_idx(x); chk("R7 index wraps 16 bits", {16'b0, x}, 32'hFFFF);
  endtask

  task automatic t_fold;
    logic [23:0] b;
    logic [15:0] x;
    wr(4'd9, 8'h00); set_base(24'h001000); set_idx(16'h0100);
    wr(4'd10, 8'h00);
    get_base(b); chk("R9 fold value 00", {8'b0, b}, 32'h001100);
    wr(4'd10, 8'hA5);
    get_base(b); chk("R9 fold value A5", {8'b0, b}, 32'h001200);
    wr(4'd9, 8'h08); set_idx(16'hFF00);
    wr(4'd10, 8'h3C);
    get_base(b); chk("R9 signed fold", {8'b0, b}, 32'h001100);
    get_idx(x); chk("R9 index unchanged", {16'b0, x}, 32'hFF00);
  endtask

  task automatic t_hi_fold;
    logic [23:0] b;
    wr(4'd9, 8'h40); set_base(24'h001000);
    wr(4'd5, 8'h20);
    get_base(b); chk("R10 low byte no fold", {8'b0, b}, 32'h001000);
    wr(4'd6, 8'h01);
    get_base(b); chk("R10 high byte folds", {8'b0, b}, 32'h001120);
    wr(4'd9, 8'h60); wr(4'd6, 8'h02);
    get_base(b); chk("R10 mode 11 no fold", {8'b0, b}, 32'h001120);
    wr(4'd9, 8'h20); wr(4'd6, 8'h03);
    get_base(b); chk("R10 mode 01 no fold", {8'b0, b}, 32'h001120);
    wr(4'd9, 8'h48); wr(4'd6, 8'hFF);
    get_base(b); chk("R10 signed high fold", {8'b0, b}, 32'h001040);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_map();
    t_direct();
    t_indexed();
    t_write();
    t_step_base();
    t_countdown();
    t_fold();
    t_hi_fold();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R11 watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule